// File: doc/BRIEF.md
# Wait and Supervisor-Return Privilege Gate

This block sits beside the instruction issue point and rules on two privileged instructions: wait-for-interrupt (WFI) and supervisor return (SRET). For each accepted instruction it checks the current privilege mode, whether supervisor mode exists in the machine, and two control bits. The first is a timed-wait enable. The second is a return-trap enable. It then lets the instruction finish, holds it in a wait state until a wake-up arrives, or raises a single-cycle illegal-instruction trap.

When a WFI runs below machine mode with the timed-wait enable set, a bounded counter watches the wait. If no wake-up arrives within `LIMIT` cycles, the wait becomes an illegal-instruction trap. `LIMIT` may be zero, and then such a WFI traps at once. The issue side is a valid/ready pair. `issue_ready` is low for as long as a WFI is waiting. An instruction is taken only on a clock edge where `issue_valid` and `issue_ready` are both high. While `issue_ready` is low, the issuer must hold the instruction back, and the block ignores `issue_valid` entirely. Mode and control inputs are sampled on the accepting edge.

Top module: `priv_wait_gate`

## Requirements
- R1: After reset, `wait_active`, `done` and `trap` are low and `issue_ready` is high.
- R2: WFI accepted in machine mode (`priv` = 2'b11) never traps, whatever the timed-wait enable `tw`. It keeps `wait_active` high until `wake` is sampled high, and `done` pulses in the next cycle.
- R3: With `tw` = 0, WFI waits without time limit and completes on `wake`. This holds in supervisor mode (`priv` = 2'b01), and in user mode (`priv` = 2'b00) when supervisor mode is absent (`s_present` = 0).
- R4: With `tw` = 1, a WFI that is permitted below machine mode holds `wait_active` high for exactly `LIMIT` cycles when no wake-up comes. `trap` then pulses in the cycle where `wait_active` falls.
- R5: A `wake` sampled during any waiting cycle, including the last one before expiry, ends the wait with a `done` pulse and no trap.
- R6: With `LIMIT` = 0 and `tw` = 1, a WFI below machine mode pulses `trap` in the cycle after acceptance and never raises `wait_active`.
- R7: With `s_present` = 1, WFI in user mode pulses `trap` in the cycle after acceptance, for either value of `tw`.
- R8: SRET (`issue_kind` = 1) in supervisor mode with the return-trap enable `tsr` = 1 pulses `trap` in the cycle after acceptance.
- R9: Any other SRET pulses `done` in the cycle after acceptance. This covers supervisor mode with `tsr` = 0 and machine mode with any `tsr`. WFI is `issue_kind` = 0.
- R10: `trap` and `done` are never high together. Each outcome is a one-cycle pulse.
- R11: `issue_ready` is low while `wait_active` is high. An `issue_valid` seen then has no effect on `trap`, `done` or `wait_active`.
- R12: The timeout counter restarts for every WFI, so a timed WFI issued after an earlier one completes again gets the full `LIMIT` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 2 | Current mode: 2'b11 machine, 2'b01 supervisor, 2'b00 user |
| s_present | input | 1 | Supervisor mode is implemented |
| tw | input | 1 | Timed-wait enable |
| tsr | input | 1 | Return-trap enable |
| issue_valid | input | 1 | An instruction is offered |
| issue_kind | input | 1 | 0 = WFI, 1 = SRET |
| issue_ready | output | 1 | Block can accept an instruction |
| wake | input | 1 | Interrupt pending, ends a wait |
| wait_active | output | 1 | A WFI is waiting |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The bench builds two copies of the block from the same stimulus. One uses `LIMIT` = 4, which keeps the full timed-wait window short: every waiting cycle, the last-cycle wake-up race and a counter restart can each be checked on exact cycles. The other uses `LIMIT` = 0, which covers the zero-limit variant in which a timed WFI becomes an immediate trap.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam logic KIND_WFI  = 1'b0;
  localparam logic KIND_SRET = 1'b1;

  typedef enum logic [1:0] {
    V_DONE       = 2'd0,
    V_TRAP       = 2'd1,
    V_WAIT_FREE  = 2'd2,
    V_WAIT_TIMED = 2'd3
  } verdict_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } state_e;
endpackage

// File: rtl/pwg_decide.sv
module pwg_decide
  import pwg_pkg::*;
#(
  parameter int LIMIT = 4
) (
  input  logic       kind,
  input  logic [1:0] priv,
  input  logic       s_present,
  input  logic       tw,
  input  logic       tsr,
  output verdict_e   verdict
);
  verdict_e timed_v;

  // A zero limit turns a timed wait into an immediate trap.
  generate
    if (LIMIT == 0) begin : g_zero
      assign timed_v = V_TRAP;
    end else begin : g_count
      assign timed_v = V_WAIT_TIMED;
    end
  endgenerate

  always_comb begin
    verdict = V_DONE;
    if (kind == KIND_WFI) begin
      if (priv == PRIV_M)
        verdict = V_WAIT_FREE;
      else if (priv == PRIV_U && s_present)
        verdict = V_TRAP;
      else if (tw)
        verdict = timed_v;
      else
        verdict = V_WAIT_FREE;
    end else begin
      if (priv == PRIV_S && tsr)
        verdict = V_TRAP;
      else
        verdict = V_DONE;
    end
  end
endmodule

// File: rtl/pwg_timer.sv
module pwg_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int EFF = (LIMIT < 1) ? 1 : LIMIT;
  localparam int CW  = (EFF > 1) ? $clog2(EFF) : 1;
  localparam logic [CW-1:0] LAST = CW'(EFF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !run)
      cnt <= '0;
    else if (cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/priv_wait_gate.sv
module priv_wait_gate
  import pwg_pkg::*;
#(
  parameter int LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] priv,
  input  logic       s_present,
  input  logic       tw,
  input  logic       tsr,
  input  logic       issue_valid,
  input  logic       issue_kind,
  output logic       issue_ready,
  input  logic       wake,
  output logic       wait_active,
  output logic       done,
  output logic       trap
);
  state_e   state;
  logic     timed_q;
  logic     done_q;
  logic     trap_q;
  logic     accept;
  logic     expired;
  logic     timer_run;
  verdict_e verdict;

  assign accept    = issue_valid && issue_ready;
  assign timer_run = (state == ST_WAIT) && timed_q && !wake;

  pwg_decide #(.LIMIT(LIMIT)) u_decide (
    .kind      (issue_kind),
    .priv      (priv),
    .s_present (s_present),
    .tw        (tw),
    .tsr       (tsr),
    .verdict   (verdict)
  );

  pwg_timer #(.LIMIT(LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .run     (timer_run),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      timed_q <= 1'b0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            case (verdict)
              V_TRAP:       trap_q <= 1'b1;
              V_DONE:       done_q <= 1'b1;
              V_WAIT_FREE: begin
                state   <= ST_WAIT;
                timed_q <= 1'b0;
              end
              V_WAIT_TIMED: begin
                state   <= ST_WAIT;
                timed_q <= 1'b1;
              end
              default:      trap_q <= 1'b1;
            endcase
          end
        end
        ST_WAIT: begin
          if (wake) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else if (expired) begin
            trap_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wait_active = (state == ST_WAIT);
  assign issue_ready = (state == ST_IDLE);
  assign done        = done_q;
  assign trap        = trap_q;
endmodule

// File: rtl/pwg_chk.sv
module pwg_chk #(
  parameter int LIMIT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] priv,
  input logic       s_present,
  input logic       tw,
  input logic       tsr,
  input logic       issue_valid,
  input logic       issue_kind,
  input logic       issue_ready,
  input logic       wake,
  input logic       wait_active,
  input logic       done,
  input logic       trap
);
  logic        acc;
  logic        timed_c;
  logic [31:0] run_c;

  assign acc = issue_valid && issue_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timed_c <= 1'b0;
      run_c   <= '0;
    end else begin
      if (acc)
        timed_c <= (issue_kind == 1'b0) && (priv != 2'b11) && tw;
      run_c <= wait_active ? run_c + 1 : '0;
    end
  end

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap && done));

  assert_m_wfi_no_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !issue_kind && priv == 2'b11) |=> !trap);

  assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (LIMIT > 0 && timed_c && wait_active) |-> (run_c < LIMIT));

  assert_wake_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_active && wake) |=> (done && !trap && !wait_active));

  assert_user_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !issue_kind && priv == 2'b00 && s_present) |=> trap);

  assert_sret_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && issue_kind && priv == 2'b01 && tsr) |=> trap);

  assert_sret_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && issue_kind && !(priv == 2'b01 && tsr)) |=> done);

  assert_wait_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_active) |-> $past(acc));
endmodule

bind priv_wait_gate pwg_chk #(.LIMIT(LIMIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .priv        (priv),
  .s_present   (s_present),
  .tw          (tw),
  .tsr         (tsr),
  .issue_valid (issue_valid),
  .issue_kind  (issue_kind),
  .issue_ready (issue_ready),
  .wake        (wake),
  .wait_active (wait_active),
  .done        (done),
  .trap        (trap)
);

// File: tb/sim_priv_wait_gate.sv
`timescale 1ns/1ps
module sim_priv_wait_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] priv = 2'b11;
  logic       s_present = 1'b1;
  logic       tw = 1'b0;
  logic       tsr = 1'b0;
  logic       issue_valid = 1'b0;
  logic       issue_kind = 1'b0;
  logic       wake = 1'b0;
  logic       ready0, wait0, done0, trap0;
  logic       ready1, wait1, done1, trap1;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  priv_wait_gate #(.LIMIT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .priv(priv), .s_present(s_present), .tw(tw),
    .tsr(tsr), .issue_valid(issue_valid), .issue_kind(issue_kind),
    .issue_ready(ready0), .wake(wake), .wait_active(wait0), .done(done0),
    .trap(trap0)
  );

  priv_wait_gate #(.LIMIT(0)) u1 (
    .clk(clk), .rst_n(rst_n), .priv(priv), .s_present(s_present), .tw(tw),
    .tsr(tsr), .issue_valid(issue_valid), .issue_kind(issue_kind),
    .issue_ready(ready1), .wake(wake), .wait_active(wait1), .done(done1),
    .trap(trap1)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Leaves the bench at the first falling edge after the accepting edge.
  task automatic issue(input logic kind, input logic [1:0] p, input logic t_w,
                       input logic t_sr, input logic sp);
    @(negedge clk);
    issue_kind = kind; priv = p; tw = t_w; tsr = t_sr; s_present = sp;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 wait", wait0, 0);
    check("R1 done", done0, 0);
    check("R1 trap", trap0, 0);
    check("R1 ready", ready0, 1);
  endtask

  task automatic wake_and_check(input string req);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check({req, " done"}, done0, 1);
    check({req, " trap"}, trap0, 0);
    check({req, " wait end"}, wait0, 0);
    @(negedge clk);
    check("R10 done one cycle", done0, 0);
  endtask

  task automatic t_m_wfi;
    issue(1'b0, 2'b11, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 7; i++) begin
      check("R2 waiting", wait0, 1);
      check("R2 no trap", trap0, 0);
      @(negedge clk);
    end
    wake_and_check("R2");
  endtask

  task automatic t_free_wait;
    issue(1'b0, 2'b01, 1'b0, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    check("R3 S waiting", wait0, 1);
    wake_and_check("R3 S");
    issue(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    check("R3 U waiting", wait0, 1);
    check("R3 U no trap", trap0, 0);
    wake_and_check("R3 U");
  endtask

  task automatic timed_expiry(input logic [1:0] p, input logic sp, input string req);
    issue(1'b0, p, 1'b1, 1'b0, sp);
    check("R6 zero limit trap", trap1, 1);
    check("R6 zero limit no wait", wait1, 0);
    for (int k = 0; k < 4; k++) begin
      check({req, " waiting"}, wait0, 1);
      check({req, " no early trap"}, trap0, 0);
      @(negedge clk);
    end
    check({req, " trap"}, trap0, 1);
    check({req, " no done"}, done0, 0);
    check({req, " wait dropped"}, wait0, 0);
    @(negedge clk);
    check("R10 trap one cycle", trap0, 0);
  endtask

  task automatic t_timeout;
    timed_expiry(2'b01, 1'b1, "R4 S");
    timed_expiry(2'b00, 1'b0, "R4 U");
  endtask

  task automatic t_late_wake;
    issue(1'b0, 2'b01, 1'b1, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R5 last waiting cycle", wait0, 1);
    wake_and_check("R5");
    timed_expiry(2'b01, 1'b1, "R12 restart");
  endtask

  task automatic t_user_with_s;
    issue(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
    check("R7 tw0 trap", trap0, 1);
    check("R7 tw0 no wait", wait0, 0);
    issue(1'b0, 2'b00, 1'b1, 1'b0, 1'b1);
    check("R7 tw1 trap", trap0, 1);
    check("R7 tw1 no wait", wait0, 0);
  endtask

  task automatic t_sret;
    issue(1'b1, 2'b01, 1'b0, 1'b1, 1'b1);
    check("R8 trap", trap0, 1);
    check("R8 no done", done0, 0);
    issue(1'b1, 2'b01, 1'b0, 1'b0, 1'b1);
    check("R9 S done", done0, 1);
    check("R9 S no trap", trap0, 0);
    issue(1'b1, 2'b11, 1'b0, 1'b1, 1'b1);
    check("R9 M done", done0, 1);
    check("R9 M no trap", trap0, 0);
  endtask

  task automatic t_busy;
    issue(1'b0, 2'b11, 1'b0, 1'b0, 1'b1);
    check("R11 ready low", ready0, 0);
    issue(1'b1, 2'b01, 1'b0, 1'b1, 1'b1);
    check("R11 ignored trap", trap0, 0);
    check("R11 ignored done", done0, 0);
    check("R11 still waiting", wait0, 1);
    @(negedge clk);
    check("R11 no late trap", trap0, 0);
    wake_and_check("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_m_wfi();
    t_free_wait();
    t_timeout();
    t_late_wake();
    t_user_with_s();
    t_sret();
    t_busy();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule